// File: doc/BRIEF.md
# Encoder-Driven Linear Tuning Controller for a Serial-Programmed DDS

The block turns the two quadrature lines of an optical shaft encoder into a dial frequency held in 10 Hz units. Every counted encoder edge moves the dial by exactly one unit, whatever the rotation speed. Edges are counted on both transitions of channel A only. A 512-line encoder therefore yields 1024 counts, or 10.24 kHz, per revolution. The dial is clamped to a parameterised window and never wraps.

A sideband select chooses one of two offsets. The offset is added to the dial to form the oscillator frequency. A two-stage pipeline multiplies that frequency by the constant `round(STEP_HZ * 2^32 / REF_HZ)` to give a 32-bit phase-increment word. A serial transmitter then shifts the word into an external DDS device, LSB first, and raises an update strobe for one serial-clock period. The serial half-period is derived from the system clock so that the bit rate never exceeds `MAX_BIT_HZ`. A new value that arrives during a transfer waits until that transfer completes. The block then sends the newest value.

The decoder has no state machine of its own; its Gray phase is simply the last synchronized {A,B} pair. The transmitter is a four-state machine:

- `TX_IDLE`: sclk low, data low. It goes to `TX_LOW` when a word is pending.
- `TX_LOW`: data shows the current bit, sclk low, for `HALF` cycles. It then goes to `TX_HIGH`.
- `TX_HIGH`: sclk high for `HALF` cycles. It goes to `TX_LOW` (shift) after bits 0 to 30, or to `TX_LOAD` after bit 31.
- `TX_LOAD`: the strobe is high and sclk is low for `2*HALF` cycles. It then returns to `TX_IDLE`.

Top module: `dds_tune_ctrl`

## Requirements
- R1: Each transition of the synchronized A line with B steady changes `dial_steps` by exactly one unit. It counts up when the new A differs from B, and down when the new A equals B. A transition of B alone changes nothing.
- R2: The phase sequence 00→10→11→01→00 (written as {A,B}) gives two up-counts per cycle. The reverse sequence gives two down-counts. The step size does not depend on the time between edges.
- R3: When A and B change in the same sampled cycle, the block counts nothing and sends no new word.
- R4: `dial_steps` stays within [DIAL_MIN, DIAL_MAX]. A count that would leave the window is dropped, and the dial holds its bound.
- R5: The transmitted word equals ((dial_steps + OFS) * K) mod 2^32, with K = round(STEP_HZ * 2^32 / REF_HZ). OFS is USB_OFS when `sb_upper`=1 and LSB_OFS when `sb_upper`=0.
- R6: A frame is 32 data bits, LSB first. `dds_sdata` changes only while `dds_sclk` is low and is sampled on its rising edge. Each sclk phase lasts HALF = ceil(CLK_HZ / (2*MAX_BIT_HZ)) system cycles.
- R7: Right after the 32nd sclk high phase, `dds_load` is high for 2*HALF cycles while `dds_sclk` stays low.
- R8: After reset one frame is sent carrying the word for DIAL_INIT and the current sideband.
- R9: A change of `sb_upper` alone starts a new frame with the other offset, and `dial_steps` does not change.
- R10: A frame in progress is never cut short. Changes that arrive during it lead to exactly one further frame carrying the latest value.
- R11: While reset is asserted, `dds_sdata`, `dds_sclk` and `dds_load` are 0 and `dial_steps` equals DIAL_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| sb_upper | input | 1 | Sideband select: 1 upper, 0 lower, asynchronous |
| dds_sdata | output | 1 | Serial tuning-word data, LSB first |
| dds_sclk | output | 1 | Serial clock, idle low |
| dds_load | output | 1 | Frequency-update strobe |
| dial_steps | output | DIAL_W | Dial frequency in STEP_HZ units, for display |

## Verification
The encoder is driven forward and backward through the Gray sequence. A forward and a backward turn tell an inverted direction rule apart from a correct one. A B-only transition inside each cycle shows whether B edges are wrongly counted. A simultaneous A/B jump must leave both the dial and the frame count untouched. Turns that run past both bounds expose wrapping or an off-by-one clamp. A sideband flip at a fixed dial isolates the offset path. A fast burst of counts during a frame shows whether the transmitter drops the newest value or cuts a frame short.

// File: rtl/dds_tune_pkg.sv
package dds_tune_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_LOW  = 2'd1,
        TX_HIGH = 2'd2,
        TX_LOAD = 2'd3
    } tx_state_e;

    // System cycles per serial-clock phase, rounded up so the bit rate stays at or below the limit
    function automatic int half_cycles(longint unsigned clk_hz, longint unsigned max_bps);
        return int'((clk_hz + 2 * max_bps - 1) / (2 * max_bps));
    endfunction

    // round(step_hz * 2^32 / ref_hz), computed with one extra fractional bit
    function automatic logic [31:0] scale_const(longint unsigned step_hz, longint unsigned ref_hz);
        longint unsigned num;
        num = step_hz << 33;
        return 32'(((num / ref_hz) + 1) >> 1);
    endfunction

endpackage

// File: rtl/quad_edge_decode.sv
module quad_edge_decode #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_a,
    input  logic enc_b,
    output logic cnt_up,
    output logic cnt_dn
);
    logic [SYNC_STAGES-1:0] a_sh, b_sh;
    logic [1:0] phase_q, phase_now;
    logic       a_chg, b_chg;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    a_sh <= '0;
                    b_sh <= '0;
                end else begin
                    a_sh <= enc_a;
                    b_sh <= enc_b;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    a_sh <= '0;
                    b_sh <= '0;
                end else begin
                    a_sh <= {a_sh[SYNC_STAGES-2:0], enc_a};
                    b_sh <= {b_sh[SYNC_STAGES-2:0], enc_b};
                end
            end
        end
    endgenerate

    assign phase_now = {a_sh[SYNC_STAGES-1], b_sh[SYNC_STAGES-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 2'b00;
        else        phase_q <= phase_now;
    end

    always_comb begin
        a_chg  = phase_q[1] ^ phase_now[1];
        b_chg  = phase_q[0] ^ phase_now[0];
        cnt_up = 1'b0;
        cnt_dn = 1'b0;
        if (a_chg && !b_chg) begin
            if (phase_now[1] != phase_now[0]) cnt_up = 1'b1;
            else                              cnt_dn = 1'b1;
        end
    end

    a_r3_double_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (a_chg && b_chg) |-> !(cnt_up || cnt_dn));
    a_r1_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_up && cnt_dn));

endmodule

// File: rtl/dial_accum.sv
module dial_accum #(
    parameter int DIAL_W   = 32,
    parameter int DIAL_MIN = 0,
    parameter int DIAL_MAX = 3_000_000,
    parameter int DIAL_INIT = 700_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_up,
    input  logic              cnt_dn,
    output logic [DIAL_W-1:0] dial_o,
    output logic              moved_o
);
    localparam logic [DIAL_W-1:0] LO = DIAL_W'(DIAL_MIN);
    localparam logic [DIAL_W-1:0] HI = DIAL_W'(DIAL_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dial_o  <= DIAL_W'(DIAL_INIT);
            moved_o <= 1'b0;
        end else begin
            moved_o <= 1'b0;
            if (cnt_up && dial_o < HI) begin
                dial_o  <= dial_o + 1'b1;
                moved_o <= 1'b1;
            end else if (cnt_dn && dial_o > LO) begin
                dial_o  <= dial_o - 1'b1;
                moved_o <= 1'b1;
            end
        end
    end

    a_r4_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (dial_o >= LO) && (dial_o <= HI));
    a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dial_o != $past(dial_o)) |-> ((dial_o == $past(dial_o) + 1'b1) || (dial_o == $past(dial_o) - 1'b1)));

endmodule

// File: rtl/tune_word_calc.sv
module tune_word_calc #(
    parameter int          DIAL_W  = 32,
    parameter int          WORD_W  = 32,
    parameter int          USB_OFS = 999_850,
    parameter int          LSB_OFS = 1_000_150,
    parameter logic [31:0] KSCALE  = 32'd344
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIAL_W-1:0] dial_i,
    input  logic              sb_upper_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o
);
    localparam int PW = DIAL_W + 32;

    logic [DIAL_W-1:0] osc_q;
    logic              v1_q;
    logic [PW-1:0]     prod_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_q      <= '0;
            v1_q       <= 1'b0;
            prod_q     <= '0;
            word_vld_o <= 1'b0;
        end else begin
            v1_q       <= start_i;
            word_vld_o <= v1_q;
            if (start_i)
                osc_q <= dial_i + (sb_upper_i ? DIAL_W'(USB_OFS) : DIAL_W'(LSB_OFS));
            if (v1_q)
                prod_q <= PW'(osc_q) * PW'(KSCALE);
        end
    end

    assign word_o = prod_q[WORD_W-1:0];

    a_r5_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> $past(start_i, 2));

endmodule

// File: rtl/dds_serial_tx.sv
module dds_serial_tx
    import dds_tune_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int HALF_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              word_vld_i,
    output logic              sdata_o,
    output logic              sclk_o,
    output logic              load_o
);
    localparam int TICK_W = $clog2(2 * HALF_CYC + 1);
    localparam int BIT_W  = $clog2(WORD_W);

    tx_state_e         state_q, state_d;
    logic [TICK_W-1:0] tick_q, tick_lim;
    logic              tick_done, last_bit;
    logic [BIT_W-1:0]  bit_q;
    logic [WORD_W-1:0] shreg_q, pend_word_q;
    logic              pend_q;

    always_comb begin
        tick_lim  = (state_q == TX_LOAD) ? TICK_W'(2 * HALF_CYC - 1) : TICK_W'(HALF_CYC - 1);
        tick_done = (tick_q == tick_lim);
        last_bit  = (bit_q == BIT_W'(WORD_W - 1));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (pend_q)    state_d = TX_LOW;
            TX_LOW:  if (tick_done) state_d = TX_HIGH;
            TX_HIGH: if (tick_done) state_d = last_bit ? TX_LOAD : TX_LOW;
            TX_LOAD: if (tick_done) state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q      <= '0;
            bit_q       <= '0;
            shreg_q     <= '0;
            pend_word_q <= '0;
            pend_q      <= 1'b0;
        end else begin
            tick_q <= (state_d != state_q || state_q == TX_IDLE) ? '0 : tick_q + 1'b1;
            if (state_q == TX_IDLE && state_d == TX_LOW) begin
                shreg_q <= pend_word_q;
                bit_q   <= '0;
            end else if (state_q == TX_HIGH && state_d == TX_LOW) begin
                shreg_q <= shreg_q >> 1;
                bit_q   <= bit_q + 1'b1;
            end
            if (word_vld_i) begin
                pend_word_q <= word_i;
                pend_q      <= 1'b1;
            end else if (state_q == TX_IDLE && state_d == TX_LOW) begin
                pend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        sdata_o = 1'b0;
        sclk_o  = 1'b0;
        load_o  = 1'b0;
        unique case (state_q)
            TX_IDLE: ;
            TX_LOW:  sdata_o = shreg_q[0];
            TX_HIGH: begin
                sdata_o = shreg_q[0];
                sclk_o  = 1'b1;
            end
            TX_LOAD: load_o = 1'b1;
        endcase
    end

    a_r6_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
    a_r7_load_follows_clk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_o) |-> $past(sclk_o));
    a_r6_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_o) |-> (bit_q == BIT_W'(WORD_W - 1)));
    a_r10_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_HIGH && !last_bit && tick_done) |=> (state_q == TX_LOW));

endmodule

// File: rtl/dds_tune_ctrl.sv
module dds_tune_ctrl
    import dds_tune_pkg::*;
#(
    parameter int              DIAL_W     = 32,
    parameter int              DIAL_MIN   = 0,
    parameter int              DIAL_MAX   = 3_000_000,
    parameter int              DIAL_INIT  = 700_000,
    parameter int              USB_OFS    = 999_850,
    parameter int              LSB_OFS    = 1_000_150,
    parameter longint unsigned STEP_HZ    = 10,
    parameter longint unsigned REF_HZ     = 125_000_000,
    parameter longint unsigned CLK_HZ     = 50_000_000,
    parameter longint unsigned MAX_BIT_HZ = 10_000_000,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              sb_upper,
    output logic              dds_sdata,
    output logic              dds_sclk,
    output logic              dds_load,
    output logic [DIAL_W-1:0] dial_steps
);
    localparam int          WORD_W = 32;
    localparam int          HALF   = half_cycles(CLK_HZ, MAX_BIT_HZ);
    localparam logic [31:0] KSC    = scale_const(STEP_HZ, REF_HZ);

    logic              up, dn, moved;
    logic [SYNC_STAGES-1:0] sb_sh;
    logic              sb_prev, sb_now, boot, sb_chg, start;
    logic [1:0]        boot_cnt;
    logic [WORD_W-1:0] word;
    logic              word_vld;

    quad_edge_decode #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .cnt_up(up), .cnt_dn(dn));

    dial_accum #(.DIAL_W(DIAL_W), .DIAL_MIN(DIAL_MIN), .DIAL_MAX(DIAL_MAX),
                 .DIAL_INIT(DIAL_INIT)) u_acc (
        .clk(clk), .rst_n(rst_n), .cnt_up(up), .cnt_dn(dn),
        .dial_o(dial_steps), .moved_o(moved));

    assign sb_now = sb_sh[SYNC_STAGES-1];

    generate
        if (SYNC_STAGES == 1) begin : g_sb_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sb_sh <= '0;
                else        sb_sh <= sb_upper;
            end
        end else begin : g_sb_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sb_sh <= '0;
                else        sb_sh <= {sb_sh[SYNC_STAGES-2:0], sb_upper};
            end
        end
    endgenerate

    // Boot request waits for the sideband chain to settle, then fires once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_cnt <= '0;
            sb_prev  <= 1'b0;
        end else begin
            sb_prev <= sb_now;
            if (boot_cnt != 2'd3) boot_cnt <= boot_cnt + 1'b1;
        end
    end

    always_comb begin
        boot   = (boot_cnt == 2'd2);
        sb_chg = (boot_cnt == 2'd3) && (sb_prev != sb_now);
        start  = boot || moved || sb_chg;
    end

    tune_word_calc #(.DIAL_W(DIAL_W), .WORD_W(WORD_W), .USB_OFS(USB_OFS),
                     .LSB_OFS(LSB_OFS), .KSCALE(KSC)) u_calc (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dial_i(dial_steps),
        .sb_upper_i(sb_now), .word_o(word), .word_vld_o(word_vld));

    dds_serial_tx #(.WORD_W(WORD_W), .HALF_CYC(HALF)) u_tx (
        .clk(clk), .rst_n(rst_n), .word_i(word), .word_vld_i(word_vld),
        .sdata_o(dds_sdata), .sclk_o(dds_sclk), .load_o(dds_load));

    a_r9_sideband_request: assert property (@(posedge clk) disable iff (!rst_n)
        sb_chg |=> ##1 word_vld);

endmodule

// File: tb/dds_tune_ctrl_tb.sv
module dds_tune_ctrl_tb_top;
    localparam time CLK_PERIOD = 20ns;
    localparam longint CLK_HZ = 50_000_000;
    localparam longint REF_HZ = 125_000_000;
    localparam longint MAXBPS = 10_000_000;
    localparam int DMIN = 2, DMAX = 20, DINIT = 5, USB = 1000, LSB = 3000;
    localparam int HALF_EXP = int'((CLK_HZ + 2 * MAXBPS - 1) / (2 * MAXBPS));
    localparam longint K_EXP = longint'($rtoi(10.0 * 4294967296.0 / real'(REF_HZ) + 0.5));

    logic clk = 0, rst_n = 0, enc_a = 0, enc_b = 0, sb_upper = 1;
    logic dds_sdata, dds_sclk, dds_load;
    logic [31:0] dial_steps;

    int checks = 0, errors = 0, frames = 0, bits = 0, hi_run = 0, ld_run = 0;
    logic [31:0] cap = '0, last_word = '0;
    logic prev_sclk = 0, prev_load = 0, ld_sclk_bad = 0, done = 0;
    int ph = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dds_tune_ctrl #(.DIAL_MIN(DMIN), .DIAL_MAX(DMAX), .DIAL_INIT(DINIT),
                    .USB_OFS(USB), .LSB_OFS(LSB), .REF_HZ(REF_HZ),
                    .CLK_HZ(CLK_HZ), .MAX_BIT_HZ(MAXBPS)) dut_i (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .sb_upper(sb_upper),
        .dds_sdata(dds_sdata), .dds_sclk(dds_sclk), .dds_load(dds_load),
        .dial_steps(dial_steps));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int dial, input bit upper);
        longint o;
        o = longint'(dial) + longint'(upper ? USB : LSB);
        return 32'(o * K_EXP);
    endfunction

    // Frame monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (dds_sclk && !prev_sclk) begin
                if (bits < 32) cap[bits] = dds_sdata;
                bits++;
                hi_run = 1;
            end else if (dds_sclk) hi_run++;
            if (!dds_sclk && prev_sclk)
                chk(hi_run == HALF_EXP, "R6", "sclk high cycles", hi_run, HALF_EXP);
            if (dds_load) begin
                ld_run++;
                if (dds_sclk) ld_sclk_bad = 1;
            end
            if (!dds_load && prev_load) begin
                chk(ld_run == 2 * HALF_EXP, "R7", "load high cycles", ld_run, 2 * HALF_EXP);
                chk(!ld_sclk_bad, "R7", "sclk low during load", ld_sclk_bad, 0);
                chk(bits == 32, "R6", "bits per frame", bits, 32);
                last_word = cap;
                frames++;
                bits = 0;
                ld_run = 0;
                ld_sclk_bad = 0;
            end
            prev_sclk = dds_sclk;
            prev_load = dds_load;
        end
    end

    function automatic logic [1:0] ab_of(input int p);
        case (p)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic turn(input int counts, input bit fwd, input int hold);
        int got = 0;
        logic [1:0] prev, nxt;
        while (got < counts) begin
            prev = ab_of(ph);
            ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
            nxt = ab_of(ph);
            @(negedge clk);
            {enc_a, enc_b} = nxt;
            if (prev[1] != nxt[1]) got++;
            repeat (hold) @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic settle();
        repeat (600) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(dial_steps == DINIT, "R11", "dial in reset", dial_steps, DINIT);
        chk({dds_sdata, dds_sclk, dds_load} == 3'b000, "R11", "serial pins in reset",
            {dds_sdata, dds_sclk, dds_load}, 0);
        rst_n = 1;
        settle();
        chk(frames == 1, "R8", "frames after reset", frames, 1);
        chk(last_word == exp_word(DINIT, 1), "R8", "boot word", last_word, exp_word(DINIT, 1));
    endtask

    task automatic t_forward();
        turn(6, 1, 5);
        chk(dial_steps == DINIT + 6, "R1", "dial after forward", dial_steps, DINIT + 6);
        settle();
        chk(last_word == exp_word(DINIT + 6, 1), "R5", "word after forward",
            last_word, exp_word(DINIT + 6, 1));
    endtask

    task automatic t_backward();
        turn(3, 0, 12);
        chk(dial_steps == DINIT + 3, "R2", "dial after reverse", dial_steps, DINIT + 3);
        settle();
        chk(last_word == exp_word(DINIT + 3, 1), "R5", "word after reverse",
            last_word, exp_word(DINIT + 3, 1));
    endtask

    task automatic t_double();
        int f0 = frames;
        logic [1:0] here, opp;
        here = ab_of(ph);
        opp = ab_of((ph + 2) % 4);
        @(negedge clk); {enc_a, enc_b} = opp;
        repeat (20) @(negedge clk);
        chk(dial_steps == DINIT + 3, "R3", "dial after double jump", dial_steps, DINIT + 3);
        {enc_a, enc_b} = here;
        settle();
        chk(dial_steps == DINIT + 3, "R3", "dial after jump back", dial_steps, DINIT + 3);
        chk(frames == f0, "R3", "frames after double jumps", frames, f0);
    endtask

    task automatic t_clamp();
        turn(DMAX, 1, 4);
        chk(dial_steps == DMAX, "R4", "dial upper clamp", dial_steps, DMAX);
        turn(DMAX + 10, 0, 4);
        chk(dial_steps == DMIN, "R4", "dial lower clamp", dial_steps, DMIN);
        settle();
        chk(last_word == exp_word(DMIN, 1), "R4", "word at lower clamp",
            last_word, exp_word(DMIN, 1));
    endtask

    task automatic t_sideband();
        int f0 = frames;
        @(negedge clk); sb_upper = 0;
        settle();
        chk(dial_steps == DMIN, "R9", "dial after sideband flip", dial_steps, DMIN);
        chk(frames == f0 + 1, "R9", "frames after sideband flip", frames, f0 + 1);
        chk(last_word == exp_word(DMIN, 0), "R9", "lower-offset word", last_word, exp_word(DMIN, 0));
    endtask

    task automatic t_burst();
        int f0 = frames;
        turn(10, 1, 3);
        chk(dial_steps == DMIN + 10, "R2", "dial after fast burst", dial_steps, DMIN + 10);
        settle();
        chk(frames - f0 >= 1 && frames - f0 < 10, "R10", "frames for burst", frames - f0, 2);
        chk(last_word == exp_word(DMIN + 10, 0), "R10", "latest word after burst",
            last_word, exp_word(DMIN + 10, 0));
    endtask

    initial begin
        t_reset();
        t_forward();
        t_backward();
        t_double();
        t_clamp();
        t_sideband();
        t_burst();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule